// File: doc/BRIEF.md
# Window Threshold Persistence Interrupt

This block watches a stream of 16-bit measurement results and decides when to interrupt a host. Every result that arrives with its ready strobe is compared with a programmable window made of a low and a high bound. A run counter tracks consecutive results that fall outside the window. When the run reaches a programmed persistence count, an interrupt is latched. The latched flag stays set until the host sends an explicit clear command.

The window test is ordered. The low bound is tested first. The high bound counts only when the low bound is not programmed above it. A persistence setting of zero turns the filter into an every-result interrupt. The latched flag is always visible as a status bit. The interrupt pin is gated by a mask and is active low. A one-clock pulse marks each new interrupt, so a power sequencer can choose to sleep after it. All outputs are registered on the clock edge that samples the strobe, which puts the decision at the end of the conversion step that produced the result.

Top module: `prox_window_irq`

## Requirements
- R1: After reset, irqStatus is 0, irqNew is 0, irqPinEn is 0 and irqPinN is 1.
- R2: A result strictly below lowThresh counts as out of range. With persistSel = 1, such a result sets irqStatus on the same clock edge that samples resultValid.
- R3: When lowThresh <= highThresh, a result strictly above highThresh counts as out of range. A result equal to either bound, or between the bounds, counts as in range.
- R4: When lowThresh > highThresh, the high bound is ignored. A result at or above lowThresh is in range even if it exceeds highThresh.
- R5: With persistSel = 0, every sampled result raises the interrupt, whatever its value.
- R6: With persistSel = N (1 to 15), the interrupt is raised by the Nth consecutive out-of-range result and not by any earlier one. The run count saturates at 15.
- R7: An in-range result resets the run of consecutive out-of-range results to zero.
- R8: Once set, irqStatus stays 1 until clearCmd is sampled. A clear with no result in the same clock returns it to 0 on that edge.
- R9: A clear command with no result in the same clock also resets the run count to zero.
- R10: If clearCmd and a result that raises the interrupt are sampled on the same clock, irqStatus is 1 after that edge. In that clock the run count follows the result, not the clear.
- R11: irqPinEn is 1 and irqPinN is 0 exactly when irqStatus is 1 and pinMask is 1. The mask has no effect on irqStatus.
- R12: irqNew is 1 for exactly the one clock in which irqStatus has just gone from 0 to 1. It stays 0 when a qualifying result arrives while irqStatus is already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resultIn | input | 16 | Measurement result |
| resultValid | input | 1 | One-clock strobe, result ready |
| lowThresh | input | 16 | Low window bound |
| highThresh | input | 16 | High window bound |
| persistSel | input | 4 | Consecutive out-of-range count needed; 0 means every result |
| pinMask | input | 1 | Enables the interrupt pin |
| clearCmd | input | 1 | Interrupt clear command |
| irqStatus | output | 1 | Latched interrupt flag |
| irqPinEn | output | 1 | Pin enable, status gated by mask |
| irqPinN | output | 1 | Active-low interrupt pin level |
| irqNew | output | 1 | One-clock pulse when an interrupt is newly raised |

## Verification
The bench targets four kinds of error.

- Bounds: it probes results equal to each bound. A design that used inclusive compares would fire on these values.
- Inverted window: it sets lowThresh above highThresh. A design that still applied the high bound would fire on values above both bounds.
- Run counter: it interrupts runs with in-range results and with clears. A counter that failed to reset, or that fired one result early or late, shows up as an interrupt on the wrong result.
- Simultaneous clear and result: it issues a clear together with a qualifying result, both while the flag is already set and while it is clear. This catches a clear that wrongly wins, and a pulse that repeats or goes missing.

// File: rtl/pif_pkg.sv
package pif_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic sample;     // a result is being taken this clock
    logic zeroCount;  // clear command without a result
  } dpCtrl_t;

  // Flags from datapath to control
  typedef struct packed {
    logic outOfRange;
    logic persistMet;
  } dpStat_t;
endpackage

// File: rtl/pif_datapath.sv
module pif_datapath
  import pif_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PERS_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] resultIn,
  input  logic [DATA_W-1:0] lowThresh,
  input  logic [DATA_W-1:0] highThresh,
  input  logic [PERS_W-1:0] persistSel,
  input  dpCtrl_t           ctrl,
  output dpStat_t           stat
);
  localparam logic [PERS_W-1:0] RUN_MAX = '1;

  logic [PERS_W-1:0] runLen;
  logic [PERS_W:0]   runNext;
  logic              belowLow;
  logic              aboveHigh;
  logic              windowOk;
  logic              outOfRange;

  // Ordered test: low bound first; high bound only for a proper window
  always_comb begin
    belowLow   = resultIn < lowThresh;
    windowOk   = lowThresh <= highThresh;
    aboveHigh  = windowOk && (resultIn > highThresh);
    outOfRange = belowLow || aboveHigh;
    runNext    = {1'b0, runLen} + 1'b1;
  end

  always_comb begin
    stat.outOfRange = outOfRange;
    stat.persistMet = (persistSel == '0) ||
                      (outOfRange && (runNext >= {1'b0, persistSel}));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
    end else if (ctrl.sample) begin
      if (!outOfRange)          runLen <= '0;
      else if (runLen != RUN_MAX) runLen <= runLen + 1'b1;
    end else if (ctrl.zeroCount) begin
      runLen <= '0;
    end
  end
endmodule

// File: rtl/pif_control.sv
module pif_control
  import pif_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    resultValid,
  input  logic    clearCmd,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    irqStatus,
  output logic    irqNew
);
  logic raise;

  always_comb begin
    ctrl.sample    = resultValid;
    ctrl.zeroCount = clearCmd && !resultValid;
    raise          = resultValid && stat.persistMet;
  end

  // Raise beats clear; clear beats hold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqStatus <= 1'b0;
      irqNew    <= 1'b0;
    end else begin
      irqNew <= raise && !irqStatus;
      if (raise)         irqStatus <= 1'b1;
      else if (clearCmd) irqStatus <= 1'b0;
    end
  end
endmodule

// File: rtl/prox_window_irq.sv
module prox_window_irq
  import pif_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PERS_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] resultIn,
  input  logic              resultValid,
  input  logic [DATA_W-1:0] lowThresh,
  input  logic [DATA_W-1:0] highThresh,
  input  logic [PERS_W-1:0] persistSel,
  input  logic              pinMask,
  input  logic              clearCmd,
  output logic              irqStatus,
  output logic              irqPinEn,
  output logic              irqPinN,
  output logic              irqNew
);
  dpCtrl_t ctrl;
  dpStat_t stat;

  pif_datapath #(.DATA_W(DATA_W), .PERS_W(PERS_W)) u_dp (
    .clk(clk), .rstN(rstN), .resultIn(resultIn),
    .lowThresh(lowThresh), .highThresh(highThresh),
    .persistSel(persistSel), .ctrl(ctrl), .stat(stat)
  );

  pif_control u_ctl (
    .clk(clk), .rstN(rstN), .resultValid(resultValid),
    .clearCmd(clearCmd), .stat(stat), .ctrl(ctrl),
    .irqStatus(irqStatus), .irqNew(irqNew)
  );

  assign irqPinEn = irqStatus && pinMask;
  assign irqPinN  = !irqPinEn;
endmodule

// File: rtl/pif_checker.sv
module pif_checker #(
  parameter int DATA_W = 16,
  parameter int PERS_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              resultValid,
  input logic [PERS_W-1:0] persistSel,
  input logic              pinMask,
  input logic              clearCmd,
  input logic              irqStatus,
  input logic              irqPinN,
  input logic              irqNew
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqStatus && !clearCmd |=> irqStatus);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    clearCmd && !resultValid |=> !irqStatus);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rstN)
    !irqStatus && !resultValid |=> !irqStatus);

  p_every_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid && (persistSel == '0) |=> irqStatus);

  p_pin_r11: assert property (@(posedge clk) disable iff (!rstN)
    !irqPinN |-> irqStatus && pinMask);

  p_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    irqNew |-> irqStatus && !$past(irqStatus));

  p_rise_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus) |-> irqNew);
endmodule

bind prox_window_irq pif_checker #(.DATA_W(DATA_W), .PERS_W(PERS_W)) u_chk (
  .clk(clk), .rstN(rstN), .resultValid(resultValid),
  .persistSel(persistSel), .pinMask(pinMask), .clearCmd(clearCmd),
  .irqStatus(irqStatus), .irqPinN(irqPinN), .irqNew(irqNew)
);

// File: tb/prox_window_irq_tb.sv
module prox_window_irq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] resultIn = '0;
  logic        resultValid = 1'b0;
  logic [15:0] lowThresh = '0;
  logic [15:0] highThresh = '0;
  logic [3:0]  persistSel = '0;
  logic        pinMask = 1'b0;
  logic        clearCmd = 1'b0;
  logic        irqStatus, irqPinEn, irqPinN, irqNew;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  logic [3:0] mCnt = '0;
  logic       mStat = 1'b0;

  always #4 clk = ~clk;

  prox_window_irq u_dut (
    .clk(clk), .rstN(rstN), .resultIn(resultIn), .resultValid(resultValid),
    .lowThresh(lowThresh), .highThresh(highThresh), .persistSel(persistSel),
    .pinMask(pinMask), .clearCmd(clearCmd), .irqStatus(irqStatus),
    .irqPinEn(irqPinEn), .irqPinN(irqPinN), .irqNew(irqNew)
  );

  function automatic logic refOor(input logic [15:0] v, input logic [15:0] lo,
                                  input logic [15:0] hi);
    if (v < lo) return 1'b1;
    if (lo > hi) return 1'b0;
    return v > hi;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic setCfg(input logic [15:0] lo, input logic [15:0] hi,
                        input logic [3:0] p, input logic m);
    lowThresh = lo; highThresh = hi; persistSel = p; pinMask = m;
  endtask

  // One clock: drive, update reference, sample after the edge
  task automatic cyc(input string tag, input logic v, input logic [15:0] val,
                     input logic clr);
    logic o, hit, expPulse;
    logic [4:0] nxt;
    resultIn = val; resultValid = v; clearCmd = clr;
    o   = refOor(val, lowThresh, highThresh);
    nxt = {1'b0, mCnt} + 5'd1;
    hit = v && (persistSel == 4'd0 || (o && nxt >= {1'b0, persistSel}));
    expPulse = hit && !mStat;
    if (v) mCnt = o ? ((mCnt == 4'd15) ? mCnt : mCnt + 4'd1) : 4'd0;
    else if (clr) mCnt = 4'd0;
    if (hit) mStat = 1'b1;
    else if (clr) mStat = 1'b0;
    @(posedge clk); #1;
    resultValid = 1'b0; clearCmd = 1'b0;
    chk(tag, "irqStatus", irqStatus, mStat);
    chk(tag, "irqNew", irqNew, expPulse);
    chk(tag, "irqPinN", irqPinN, !(mStat && pinMask));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1", "irqStatus", irqStatus, 0);
    chk("R1", "irqNew", irqNew, 0);
    chk("R1", "irqPinEn", irqPinEn, 0);
    chk("R1", "irqPinN", irqPinN, 1);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);

    // R2 below low bound, persistence 1
    setCfg(16'd100, 16'd200, 4'd1, 1'b1);
    cyc("R2", 1, 16'd99, 0);
    chk("R2", "irqStatus literal", irqStatus, 1);
    chk("R12", "irqNew literal", irqNew, 1);
    chk("R11", "irqPinEn literal", irqPinEn, 1);
    // R8 hold over idle clocks, then clear
    cyc("R8", 0, 16'd0, 0);
    cyc("R8", 0, 16'd0, 0);
    chk("R8", "irqStatus hold", irqStatus, 1);
    chk("R12", "irqNew one clock", irqNew, 0);
    cyc("R8", 0, 16'd0, 1);
    chk("R8", "irqStatus cleared", irqStatus, 0);

    // R3 bound equality is in range, above high is out
    cyc("R3", 1, 16'd200, 0);
    cyc("R3", 1, 16'd100, 0);
    cyc("R3", 1, 16'd150, 0);
    chk("R3", "equal bounds no irq", irqStatus, 0);
    cyc("R3", 1, 16'd201, 0);
    chk("R3", "above high", irqStatus, 1);
    cyc("R8", 0, 16'd0, 1);

    // R4 inverted window ignores high bound
    setCfg(16'd300, 16'd200, 4'd1, 1'b1);
    cyc("R4", 1, 16'd350, 0);
    cyc("R4", 1, 16'd300, 0);
    chk("R4", "high ignored", irqStatus, 0);
    cyc("R4", 1, 16'd299, 0);
    chk("R4", "below low", irqStatus, 1);
    cyc("R8", 0, 16'd0, 1);

    // R5 persistence zero fires on in-range result
    setCfg(16'd100, 16'd200, 4'd0, 1'b1);
    cyc("R5", 1, 16'd150, 0);
    chk("R5", "every result", irqStatus, 1);
    cyc("R8", 0, 16'd0, 1);

    // R6 three consecutive needed
    setCfg(16'd100, 16'd200, 4'd3, 1'b1);
    cyc("R6", 1, 16'd50, 0);
    cyc("R6", 1, 16'd50, 0);
    chk("R6", "not yet", irqStatus, 0);
    cyc("R6", 1, 16'd50, 0);
    chk("R6", "third", irqStatus, 1);
    cyc("R8", 0, 16'd0, 1);

    // R7 in-range result breaks the run
    cyc("R7", 1, 16'd50, 0);
    cyc("R7", 1, 16'd50, 0);
    cyc("R7", 1, 16'd150, 0);
    cyc("R7", 1, 16'd50, 0);
    cyc("R7", 1, 16'd50, 0);
    chk("R7", "run restarted", irqStatus, 0);
    cyc("R7", 1, 16'd50, 0);
    chk("R7", "run complete", irqStatus, 1);
    cyc("R8", 0, 16'd0, 1);

    // R9 clear resets run
    setCfg(16'd100, 16'd200, 4'd2, 1'b1);
    cyc("R9", 1, 16'd50, 0);
    cyc("R9", 0, 16'd0, 1);
    cyc("R9", 1, 16'd50, 0);
    chk("R9", "run reset by clear", irqStatus, 0);
    cyc("R9", 1, 16'd50, 0);
    chk("R9", "run complete", irqStatus, 1);

    // R10 clear and qualifying result together, flag set
    setCfg(16'd100, 16'd200, 4'd1, 1'b1);
    cyc("R10", 1, 16'd50, 1);
    chk("R10", "raise wins", irqStatus, 1);
    chk("R12", "no repeat pulse", irqNew, 0);
    // R10 with flag clear
    cyc("R8", 0, 16'd0, 1);
    cyc("R10", 1, 16'd50, 1);
    chk("R10", "raise from clear", irqStatus, 1);
    chk("R12", "new pulse", irqNew, 1);

    // R11 mask off
    pinMask = 1'b0;
    cyc("R11", 0, 16'd0, 0);
    chk("R11", "status unmasked", irqStatus, 1);
    chk("R11", "pin idle", irqPinN, 1);
    chk("R11", "pin enable", irqPinEn, 0);
    // R12 already set, qualifying result
    cyc("R12", 1, 16'd50, 0);
    chk("R12", "no pulse when set", irqNew, 0);
    cyc("R8", 0, 16'd0, 1);

    // R6 saturation: persistence 15 over long run
    setCfg(16'd100, 16'd200, 4'd15, 1'b1);
    for (int i = 0; i < 20; i++) cyc("R6", 1, 16'd10, 0);
    cyc("R8", 0, 16'd0, 1);

    // Random mix
    for (int i = 0; i < 2000; i++) begin
      if (i % 40 == 0)
        setCfg(16'($urandom_range(0, 63)), 16'($urandom_range(0, 63)),
               4'($urandom_range(0, 5)), 1'($urandom_range(0, 1)));
      cyc("R2", 1'($urandom_range(0, 3) != 0), 16'($urandom_range(0, 70)),
          1'($urandom_range(0, 9) == 0));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule